// File: doc/BRIEF.md
# CAN Frame Error Detector

This block sits beside a CAN protocol engine and checks every sampled bus bit for the five CAN error classes: bit, stuff, CRC, form and acknowledge. It takes a one-cycle sample strobe for each bit time. With each strobe it receives the bus level, the level this node drives, a flag that says whether this node is the transmitter, and a field code from the frame sequencer. It keeps its own destuffing run counter and CRC register, so the sequencer only has to say which field the current bit belongs to. Stuff bits keep the field code of the field they sit in.

When an error is found, the block raises an error-frame start request for one bit time, together with a one-hot code for the error class. Bit, stuff, form and acknowledge errors raise the request in the bit right after the offending one. A CRC mismatch is held back until the ACK delimiter has gone by. A retransmit request is raised alongside the start request when this node was sending, unless single-shot operation is selected. Levels are 1 for recessive and 0 for dominant.

Top module: `can_err_detect`

## Requirements
- R1: A bit error is flagged when this node is transmitting, the field is not idle, and the sampled level differs from the driven level.
- R2: Within fields 1 to 5 (start of frame through CRC sequence), the sixth consecutive equal bit is a stuff error. The first bit after five equal bits is a stuff bit; it is excluded from the CRC and restarts the run count at one.
- R3: A form error is flagged, only when receiving, for a dominant sample in the CRC delimiter, ACK delimiter, end of frame, error delimiter or overload delimiter.
- R4: An ACK error is flagged, only when transmitting, for a recessive sample in the ACK slot.
- R5: Driving recessive and sampling dominant raises no bit error in the arbitration field or in the ACK slot.
- R6: Outputs change only on a sample strobe. An error seen at strobe k shows `ef_start` high and a one-hot `err_type` from strobe k until strobe k+1. The type bits are 0 bit, 1 stuff, 2 CRC, 3 form and 4 ACK; without an error `err_type` is zero.
- R7: When receiving, the 15-bit CRC (polynomial 0x4599, cleared at start of frame, fed with destuffed bits from start of frame through the CRC sequence) must end at zero. Otherwise a CRC error is reported with the ACK delimiter strobe, and no earlier.
- R8: When errors coincide on one bit, only the highest is reported, in the order bit, stuff, form, ACK, CRC.
- R9: `retx_req` goes high with `ef_start` when the error occurs while transmitting and `single_shot` is low; otherwise it stays low.
- R10: After reset, `ef_start`, `err_type` and `retx_req` are all zero.
- R11: Field codes: 0 idle, 1 start of frame, 2 arbitration, 3 control, 4 data, 5 CRC sequence, 6 CRC delimiter, 7 ACK slot, 8 ACK delimiter, 9 end of frame, 10 error flag, 11 error delimiter, 12 overload flag, 13 overload delimiter. No error is raised in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp | input | 1 | One-cycle strobe per sampled bit |
| rx_bit | input | 1 | Sampled bus level |
| tx_bit | input | 1 | Level driven by this node |
| tx_active | input | 1 | This node is the transmitter |
| field | input | 4 | Field code of the current bit |
| single_shot | input | 1 | Suppress retransmission |
| ef_start | output | 1 | Error frame start request |
| err_type | output | 5 | One-hot error class |
| retx_req | output | 1 | Retransmit the aborted frame |

## Verification
The assertions assume that `smp` is a single-cycle pulse and that strobes are at least two clocks apart. They also assume that `field` carries only legal codes and that `tx_active` does not change between the CRC delimiter and the ACK delimiter of a frame. The bench drives every bit through one task that holds the inputs steady, pulses the strobe once and waits two clocks. Each isolated vector starts with a start-of-frame bit, which clears the stuff run and any pending CRC error. Frames are stuffed by the bench itself, so the inputs follow the field order that a sequencer would produce.

// File: rtl/can_err_detect.sv
module can_err_detect #(
  parameter int               FW        = 4,
  parameter int               CRC_W     = 15,
  parameter logic [CRC_W-1:0] CRC_POLY  = 15'h4599,
  parameter int               STUFF_LEN = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp,
  input  logic          rx_bit,
  input  logic          tx_bit,
  input  logic          tx_active,
  input  logic [FW-1:0] field,
  input  logic          single_shot,
  output logic          ef_start,
  output logic [4:0]    err_type,
  output logic          retx_req
);
  localparam int RW = $clog2(STUFF_LEN + 1);
  localparam logic [FW-1:0] F_IDLE = 0, F_SOF = 1, F_ARB = 2, F_DATA = 4,
    F_CRC_SEQ = 5, F_CRC_DELIM = 6, F_ACK_SLOT = 7, F_ACK_DELIM = 8,
    F_EOF = 9, F_ERR_DELIM = 11, F_OVL_DELIM = 13;

  logic [RW-1:0]    run_cnt;
  logic             last_lvl;
  logic [CRC_W-1:0] crc;
  logic             crc_pend;
  logic [4:0]       typ_nxt;

  wire is_sof    = field == F_SOF;
  wire in_stuff  = field >= F_SOF && field <= F_CRC_SEQ;
  wire stuff_pos = in_stuff && !is_sof && run_cnt == RW'(STUFF_LEN);
  wire e_stuff   = stuff_pos && rx_bit == last_lvl;

  wire crc_feed = !stuff_pos && ((field >= F_SOF && field <= F_DATA) || field == F_CRC_SEQ);
  wire [CRC_W-1:0] crc_base = is_sof ? '0 : crc;
  wire crc_fb = rx_bit ^ crc_base[CRC_W-1];
  wire [CRC_W-1:0] crc_step = {crc_base[CRC_W-2:0], 1'b0} ^ (crc_fb ? CRC_POLY : '0);

  wire lost_arb = tx_bit && !rx_bit && (field == F_ARB || field == F_ACK_SLOT);
  wire e_bit    = tx_active && field != F_IDLE && rx_bit != tx_bit && !lost_arb;
  wire fixed    = field == F_CRC_DELIM || field == F_ACK_DELIM || field == F_EOF ||
                  field == F_ERR_DELIM || field == F_OVL_DELIM;
  wire e_form   = !tx_active && fixed && !rx_bit;
  wire e_ack    = tx_active && field == F_ACK_SLOT && rx_bit;
  wire e_crc    = !tx_active && field == F_CRC_DELIM && crc != '0;
  wire crc_due  = crc_pend && field == F_ACK_DELIM;

  always_comb begin
    if (e_bit)        typ_nxt = 5'b00001;
    else if (e_stuff) typ_nxt = 5'b00010;
    else if (e_form)  typ_nxt = 5'b01000;
    else if (e_ack)   typ_nxt = 5'b10000;
    else if (crc_due) typ_nxt = 5'b00100;
    else              typ_nxt = 5'b00000;
  end

  wire fire = |typ_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ef_start <= 1'b0;
      err_type <= '0;
      retx_req <= 1'b0;
      crc_pend <= 1'b0;
      run_cnt  <= '0;
      last_lvl <= 1'b1;
      crc      <= '0;
    end else if (smp) begin
      ef_start <= fire;
      err_type <= typ_nxt;
      retx_req <= fire && tx_active && !single_shot;

      if (is_sof || fire) crc_pend <= 1'b0;
      else if (e_crc)     crc_pend <= 1'b1;

      if (is_sof || (in_stuff && (stuff_pos || rx_bit != last_lvl))) begin
        run_cnt  <= RW'(1);
        last_lvl <= rx_bit;
      end else if (in_stuff) begin
        run_cnt <= run_cnt + RW'(1);
      end

      if (crc_feed) crc <= crc_step;
    end
  end
endmodule

// File: rtl/can_err_detect_chk.sv
module can_err_detect_chk #(parameter int FW = 4) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp,
  input logic          rx_bit,
  input logic          tx_bit,
  input logic          tx_active,
  input logic [FW-1:0] field,
  input logic          single_shot,
  input logic          ef_start,
  input logic [4:0]    err_type,
  input logic          retx_req
);
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_type));
  p_start_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ef_start == (err_type != 5'b0));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp |=> $stable({ef_start, err_type, retx_req}));
  p_form_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp && tx_active |=> !err_type[3]);
  p_ack_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp && !tx_active |=> !err_type[4]);
  p_crc_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp && tx_active |=> !err_type[2]);
  p_retx_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retx_req |-> ef_start);
  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp && single_shot |=> !retx_req);
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    smp && field == '0 |=> !ef_start);
endmodule

bind can_err_detect can_err_detect_chk #(.FW(FW)) u_chk (.*);

// File: tb/test_can_err_detect.sv
module test_can_err_detect;
  logic clk = 0, rst_n = 0, smp = 0, rx_bit = 1, tx_bit = 1, tx_active = 0, single_shot = 0;
  logic [3:0] field = 0;
  logic ef_start, retx_req;
  logic [4:0] err_type;
  int checks = 0, errors = 0;
  bit done = 0, seen_ef = 0;
  int b_run; logic b_last; logic [14:0] b_crc;

  always #2 clk = ~clk;

  can_err_detect i_can_err_detect (.clk, .rst_n, .smp, .rx_bit, .tx_bit, .tx_active,
    .field, .single_shot, .ef_start, .err_type, .retx_req);

  // vector: {field[3:0], tx_active, tx_bit, rx_bit, expected err_type[4:0]}
  localparam logic [11:0] VEC [15] = '{
    {4'd2,  3'b110, 5'b00000},  // R5 lost arbitration
    {4'd2,  3'b101, 5'b00001},  // R1
    {4'd4,  3'b110, 5'b00001},  // R1
    {4'd7,  3'b110, 5'b00000},  // R5 acknowledged
    {4'd7,  3'b111, 5'b10000},  // R4
    {4'd7,  3'b011, 5'b00000},  // R4 receiver
    {4'd6,  3'b010, 5'b01000},  // R3
    {4'd9,  3'b010, 5'b01000},  // R3
    {4'd8,  3'b011, 5'b00000},  // R3 legal delimiter
    {4'd9,  3'b110, 5'b00001},  // R1 transmitter in EOF
    {4'd11, 3'b010, 5'b01000},  // R3
    {4'd12, 3'b101, 5'b00001},  // R1 overload flag
    {4'd0,  3'b101, 5'b00000},  // R11 idle
    {4'd13, 3'b010, 5'b01000},  // R3
    {4'd7,  3'b101, 5'b00001}   // R8 bit beats ACK
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic [3:0] f, input logic ta, input logic tb, input logic rb);
    @(negedge clk); field = f; tx_active = ta; tx_bit = tb; rx_bit = rb; smp = 1;
    @(negedge clk); smp = 0;
    @(negedge clk);
    if (ef_start) seen_ef = 1;
  endtask

  function automatic logic [14:0] crc_upd(input logic [14:0] c, input logic b);
    logic f = b ^ c[14];
    c = {c[13:0], 1'b0};
    if (f) c = c ^ 15'h4599;
    return c;
  endfunction

  task automatic send_stuffed(input logic [3:0] f, input logic b, input bit feed);
    if (b_run == 5) begin
      send_bit(f, 0, 1, ~b_last);
      b_last = ~b_last; b_run = 1;
    end
    send_bit(f, 0, 1, b);
    if (feed) b_crc = crc_upd(b_crc, b);
    if (b == b_last) b_run++; else begin b_run = 1; b_last = b; end
  endtask

  task automatic send_frame(input logic [10:0] id, input logic [6:0] ctl,
                            input logic [7:0] dat, input bit corrupt);
    logic [14:0] c;
    b_crc = 15'h0;
    send_bit(4'd1, 0, 1, 0); b_run = 1; b_last = 0; b_crc = crc_upd(b_crc, 1'b0);
    for (int i = 10; i >= 0; i--) send_stuffed(4'd2, id[i], 1);
    for (int i = 6; i >= 0; i--) send_stuffed(4'd3, ctl[i], 1);
    for (int i = 7; i >= 0; i--) send_stuffed(4'd4, dat[i], 1);
    c = b_crc ^ (corrupt ? 15'h0010 : 15'h0);
    for (int i = 14; i >= 0; i--) send_stuffed(4'd5, c[i], 0);
    send_bit(4'd6, 0, 1, 1);
    send_bit(4'd7, 0, 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!ef_start && err_type == 0 && !retx_req, "R10 reset", {ef_start, err_type, retx_req}, 0);
    rst_n = 1;

    foreach (VEC[k]) begin
      logic [11:0] v = VEC[k];
      logic exp_retx = (v[4:0] != 0) && v[7];
      send_bit(4'd1, v[7], 0, 0);
      send_bit(v[11:8], v[7], v[6], v[5]);
      check(err_type == v[4:0], "R1/R3/R4/R5/R8/R11 vector type", err_type, v[4:0]);
      check(ef_start == (v[4:0] != 0), "R6 vector start", ef_start, v[4:0] != 0);
      check(retx_req == exp_retx, "R9 vector retx", retx_req, exp_retx);
    end

    // R6: held for one bit, cleared at the next strobe
    send_bit(4'd1, 1, 0, 0);
    send_bit(4'd7, 1, 1, 1);
    repeat (3) @(negedge clk);
    check(ef_start && err_type == 5'b10000, "R6 held between strobes", err_type, 5'h10);
    send_bit(4'd0, 0, 1, 1);
    check(!ef_start && err_type == 0, "R6 cleared next strobe", err_type, 0);
    // R6: no change without a strobe
    @(negedge clk); field = 4'd7; tx_active = 1; tx_bit = 1; rx_bit = 1;
    repeat (4) @(negedge clk);
    check(!ef_start, "R6 no strobe no change", ef_start, 0);

    // R2: six equal bits
    send_bit(4'd1, 0, 1, 0);
    for (int i = 0; i < 4; i++) send_bit(4'd2, 0, 1, 0);
    check(!ef_start, "R2 five equal bits legal", ef_start, 0);
    send_bit(4'd2, 0, 1, 0);
    check(err_type == 5'b00010, "R2 sixth equal bit", err_type, 5'h02);
    // R2: stuff bit restarts the run
    send_bit(4'd1, 0, 1, 0);
    for (int i = 0; i < 4; i++) send_bit(4'd2, 0, 1, 0);
    send_bit(4'd2, 0, 1, 1);
    for (int i = 0; i < 4; i++) send_bit(4'd2, 0, 1, 1);
    check(!ef_start, "R2 stuff bit accepted, run restarted", ef_start, 0);
    send_bit(4'd2, 0, 1, 1);
    check(err_type == 5'b00010, "R2 run counts from stuff bit", err_type, 5'h02);
    // R2: runs outside stuffed region are legal
    for (int i = 0; i < 7; i++) send_bit(4'd9, 0, 1, 1);
    check(!ef_start, "R2 end of frame not stuffed", ef_start, 0);

    // R7: correct frame
    seen_ef = 0;
    send_frame(11'h0C8, 7'h01, 8'h00, 0);
    send_bit(4'd8, 0, 1, 1);
    check(!seen_ef, "R7 good frame no error", seen_ef, 0);
    // R7: corrupted CRC, deferred report
    seen_ef = 0;
    send_frame(11'h3F1, 7'h02, 8'hA5, 1);
    check(!seen_ef, "R7 no report before ACK delimiter", seen_ef, 0);
    send_bit(4'd8, 0, 1, 1);
    check(ef_start && err_type == 5'b00100, "R7 CRC after ACK delimiter", err_type, 5'h04);
    check(!retx_req, "R9 receiver no retx", retx_req, 0);

    // R9: single shot
    single_shot = 1;
    send_bit(4'd1, 1, 0, 0);
    send_bit(4'd7, 1, 1, 1);
    check(ef_start && !retx_req, "R9 single shot suppresses retx", retx_req, 0);
    single_shot = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule